// File: doc/BRIEF.md
# SAR Converter Host Sampling Sequencer

This block sits on the host side of a parallel-output successive-approximation converter and runs it through an endless loop. Each pass has four steps: acquire, start a conversion, wait on the converter's busy flag, then read the result. The block drives four active-low strobes: convert-start, chip-select, read, and a combined reset/power-down line. It also drives an active-high byte-select. Every minimum width, hold and quiet interval is a parameter counted in system-clock cycles. The sequencer never lets a strobe change faster than those counts allow.

The 14-bit result comes back in one of two ways: a single full-width read, or two reads over an 8-bit lane, upper part first. It leaves on a valid/ready port and stays there until it is accepted. While a result is waiting, no new conversion is started, so nothing is overwritten. A running conversion can be aborted on request. A reset pulse can also be sent to the converter. After that pulse, and after the block's own reset, the first conversions are thrown away and the first acquisition is made longer so the converter can settle.

Top module: `sar_host_seq`

## Requirements
- R1: While `rstN` is low, `cnvStN`, `csN`, `rdN` and `pwdRstN` are high, `byteSel` is low and `resValid` is low.
- R2: Every sample starts with `csN` falling while `cnvStN` is high. `cnvStN` falls no earlier than ACQ_CYC cycles after that edge. No edge on `csN` or `rdN` occurs in the QUIET_CYC cycles before `cnvStN` falls.
- R3: `cnvStN` stays low for CNV_LOW_CYC cycles, then rises together with `csN`. No read starts until `busy` has been seen high and then low again.
- R4: In word mode (`byteMode` = 0), `csN` and `rdN` go low after `busy` falls. After RD_CYC cycles, all 14 bits of `dataIn` are taken as the straight-binary result.
- R5: In byte mode (`byteMode` = 1), the first read holds `byteSel` at 0 and takes result bits 13..6 from `dataIn[13:6]`. The second read holds `byteSel` at 1 and takes result bits 5..0 from `dataIn[13:8]`. Each read phase lasts RD_CYC cycles.
- R6: `resValid` stays high with `resData` unchanged until `resReady` is high. While a result waits, no new sample is started unless results are being discarded.
- R7: A pulse on `abortReq` during a conversion pulls `csN` low while `cnvStN` is high and `busy` is high. This happens at least ABORT_SU_CYC cycles after `cnvStN` rose. `csN` is held low until `busy` drops. That conversion yields no result, and sampling then resumes.
- R8: A pulse on `cvtResetReq` while idle drives `pwdRstN` low for exactly RST_CYC cycles.
- R9: After `rstN` is released and after each reset pulse, the next DROP_CNT completed conversions are read and discarded, never presented on `resData`.
- R10: The first acquisition after `rstN` is released or after a reset pulse lasts at least ACQ_CYC + WAKE_CYC cycles.
- R11: While `enable` is low, no new sample is started. A conversion already in progress completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of the block |
| enable | input | 1 | Allows new samples to start |
| byteMode | input | 1 | 1 selects the two-read 8-bit transfer; sampled at the start of each sample |
| cvtResetReq | input | 1 | Request for a converter reset pulse; served when idle |
| abortReq | input | 1 | Request to abort the conversion in progress |
| busy | input | 1 | Converter busy flag, active high |
| dataIn | input | 14 | Converter data bus |
| cnvStN | output | 1 | Convert-start, active low |
| csN | output | 1 | Chip-select, active low |
| rdN | output | 1 | Read strobe, active low |
| byteSel | output | 1 | 1 selects the low-order part in byte mode |
| pwdRstN | output | 1 | Converter reset/power-down line, active low |
| resData | output | 14 | Captured result, straight binary |
| resValid | output | 1 | `resData` holds an unaccepted result |
| resReady | input | 1 | Consumer accepts `resData` |

## Verification
The in-RTL properties are evaluated on every cycle and cover the following:
- the convert-start low width;
- the quiet gap before each start;
- that read begins only after busy falls;
- the exact reset pulse width;
- the abort setup interval;
- that a waiting result is held and never overwritten;
- that discarded conversions never raise `resValid`.

Some behaviour is visible only through the bench's converter model and its scoreboard:
- that the data reaching the output equals what the converter produced, in both transfer modes;
- that exactly the first four conversions after each reset vanish;
- that the first acquisition after a reset is longer;
- that an aborted conversion leaves no trace while sampling continues.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTP,
    ST_ACQ,
    ST_CLOW,
    ST_CONV,
    ST_ABRT,
    ST_RDHI,
    ST_RDLO
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capHi;     // store upper lane (byte mode, first read)
    logic capFinal;  // last capture of a sample: assemble and commit
    logic armDrop;   // reload discard counter after a converter reset
    logic byteMode;  // transfer mode latched for this sample
  } dpStrobe_t;

  // Converter-facing strobe set
  typedef struct packed {
    logic cnvStN;
    logic csN;
    logic rdN;
    logic byteSel;
    logic pwdRstN;
  } pinSet_t;

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int ACQ_CYC      = 8,
  parameter int QUIET_CYC    = 3,
  parameter int CNV_LOW_CYC  = 2,
  parameter int RD_CYC       = 3,
  parameter int ABORT_SU_CYC = 2,
  parameter int RST_CYC      = 10,
  parameter int WAKE_CYC     = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      byteModeIn,
  input  logic      cvtResetReq,
  input  logic      abortReq,
  input  logic      busy,
  input  logic      slotFree,
  output pinSet_t   pins,
  output dpStrobe_t strobe
);

  // Zero-valued timing parameters are lifted to one cycle
  localparam int ACQ_EFF  = maxOf(atLeastOne(ACQ_CYC), atLeastOne(QUIET_CYC));
  localparam int QUIET_EFF = atLeastOne(QUIET_CYC);
  localparam int LOW_EFF  = atLeastOne(CNV_LOW_CYC);
  localparam int RD_EFF   = atLeastOne(RD_CYC);
  localparam int SU_EFF   = atLeastOne(ABORT_SU_CYC);
  localparam int RST_EFF  = atLeastOne(RST_CYC);
  localparam int WAKE_EFF = atLeastOne(WAKE_CYC);
  localparam int CNT_W    = $clog2(ACQ_EFF + WAKE_EFF + RST_EFF + LOW_EFF + RD_EFF + SU_EFF + 2);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             busySeen, busySeenNxt;
  logic             abortPend, abortPendNxt;
  logic             wakePend, wakePendNxt;
  logic             modeQ, modeNxt;

  function automatic pinSet_t pinsFor(input seqState_t s);
    pinSet_t p;
    p = '{cnvStN: 1'b1, csN: 1'b1, rdN: 1'b1, byteSel: 1'b0, pwdRstN: 1'b1};
    case (s)
      ST_RSTP: p.pwdRstN = 1'b0;
      ST_ACQ:  p.csN = 1'b0;
      ST_CLOW: begin p.csN = 1'b0; p.cnvStN = 1'b0; end
      ST_ABRT: p.csN = 1'b0;
      ST_RDHI: begin p.csN = 1'b0; p.rdN = 1'b0; end
      ST_RDLO: begin p.csN = 1'b0; p.rdN = 1'b0; p.byteSel = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    stateNxt     = state;
    cntNxt       = cnt;
    busySeenNxt  = busySeen;
    abortPendNxt = abortPend;
    wakePendNxt  = wakePend;
    modeNxt      = modeQ;
    strobe       = '0;
    strobe.byteMode = modeQ;
    case (state)
      ST_IDLE: begin
        busySeenNxt  = 1'b0;
        abortPendNxt = 1'b0;
        if (cvtResetReq) begin
          stateNxt = ST_RSTP;
          cntNxt   = CNT_W'(RST_EFF - 1);
        end else if (enable && slotFree) begin
          stateNxt    = ST_ACQ;
          modeNxt     = byteModeIn;
          wakePendNxt = 1'b0;
          cntNxt      = wakePend ? CNT_W'(ACQ_EFF + WAKE_EFF - 1) : CNT_W'(ACQ_EFF - 1);
        end
      end
      ST_RSTP: begin
        if (cnt == '0) begin
          stateNxt       = ST_IDLE;
          wakePendNxt    = 1'b1;
          strobe.armDrop = 1'b1;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_ACQ: begin
        if (cnt == '0) begin
          stateNxt = ST_CLOW;
          cntNxt   = CNT_W'(LOW_EFF - 1);
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_CLOW: begin
        if (busy) busySeenNxt = 1'b1;
        if (abortReq) abortPendNxt = 1'b1;
        if (cnt == '0) begin
          stateNxt = ST_CONV;
          cntNxt   = '0;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_CONV: begin
        if (busy) busySeenNxt = 1'b1;
        if (abortReq) abortPendNxt = 1'b1;
        if (busySeen && !busy) begin
          stateNxt = ST_RDHI;
          cntNxt   = CNT_W'(RD_EFF - 1);
        end else if (abortPend && busySeen && busy && (cnt >= CNT_W'(SU_EFF - 1))) begin
          stateNxt = ST_ABRT;
        end else if (cnt != '1) begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_ABRT: begin
        if (!busy) stateNxt = ST_IDLE;
      end
      ST_RDHI: begin
        if (cnt == '0) begin
          if (modeQ) begin
            strobe.capHi = 1'b1;
            stateNxt     = ST_RDLO;
            cntNxt       = CNT_W'(RD_EFF - 1);
          end else begin
            strobe.capFinal = 1'b1;
            stateNxt        = ST_IDLE;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_RDLO: begin
        if (cnt == '0) begin
          strobe.capFinal = 1'b1;
          stateNxt        = ST_IDLE;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busySeen  <= 1'b0;
      abortPend <= 1'b0;
      wakePend  <= 1'b1;
      modeQ     <= 1'b0;
      pins      <= pinsFor(ST_IDLE);
    end else begin
      state     <= stateNxt;
      cnt       <= cntNxt;
      busySeen  <= busySeenNxt;
      abortPend <= abortPendNxt;
      wakePend  <= wakePendNxt;
      modeQ     <= modeNxt;
      pins      <= pinsFor(stateNxt);
    end
  end

  // Pin-level run counters feeding the properties below
  logic [CNT_W-1:0] lowRun, highRun, quietRun, rstRun;
  logic             prevCs, prevRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun   <= '0;
      highRun  <= '0;
      quietRun <= '0;
      rstRun   <= '0;
      prevCs   <= 1'b1;
      prevRd   <= 1'b1;
    end else begin
      prevCs   <= pins.csN;
      prevRd   <= pins.rdN;
      lowRun   <= pins.cnvStN ? '0 : ((lowRun == '1) ? lowRun : lowRun + 1'b1);
      highRun  <= !pins.cnvStN ? '0 : ((highRun == '1) ? highRun : highRun + 1'b1);
      rstRun   <= pins.pwdRstN ? '0 : ((rstRun == '1) ? rstRun : rstRun + 1'b1);
      if (pins.csN != prevCs || pins.rdN != prevRd) quietRun <= '0;
      else if (quietRun != '1) quietRun <= quietRun + 1'b1;
    end
  end

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pins.cnvStN) |-> (quietRun >= CNT_W'(QUIET_EFF - 1)) && !pins.csN); // R2
  AST_START_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pins.cnvStN) |-> (lowRun == CNT_W'(LOW_EFF)) && pins.csN); // R3
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pins.rdN) |-> pins.cnvStN && !busy); // R4
  AST_ABORT_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pins.csN) && busy) |-> pins.cnvStN && (highRun >= CNT_W'(SU_EFF))); // R7
  AST_RESET_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pins.pwdRstN) |-> rstRun == CNT_W'(RST_EFF)); // R8

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int BYTE_W   = 8,
  parameter int DROP_CNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              resReady,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              slotFree
);

  localparam int LO_W   = DATA_W - BYTE_W;
  localparam int DROP_W = $clog2(DROP_CNT + 2);

  logic [DROP_W-1:0] dropLeft;
  logic [DATA_W-1:0] splitWord;
  logic [DATA_W-1:0] finalWord;
  logic              dropping;

  generate
    if (LO_W > 0) begin : gSplit
      logic [BYTE_W-1:0] hiReg;
      always_ff @(posedge clk) begin
        if (!rstN) hiReg <= '0;
        else if (strobe.capHi) hiReg <= dataIn[DATA_W-1 -: BYTE_W];
      end
      assign splitWord = {hiReg, dataIn[DATA_W-1 -: LO_W]};
    end else begin : gWhole
      assign splitWord = dataIn;
    end
  endgenerate

  assign finalWord = strobe.byteMode ? splitWord : dataIn;
  assign dropping  = (dropLeft != '0);
  assign slotFree  = !resValid || dropping;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropLeft <= DROP_W'(DROP_CNT);
      resValid <= 1'b0;
      resData  <= '0;
    end else begin
      if (resValid && resReady) resValid <= 1'b0;
      if (strobe.armDrop) begin
        dropLeft <= DROP_W'(DROP_CNT);
      end else if (strobe.capFinal) begin
        if (dropping) begin
          dropLeft <= dropLeft - 1'b1;
        end else begin
          resData  <= finalWord;
          resValid <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> resValid && $stable(resData)); // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady && !dropping) |-> !strobe.capFinal); // R6
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capFinal && dropping && !resValid) |=> !resValid); // R9

endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int BYTE_W       = 8,
  parameter int ACQ_CYC      = 8,
  parameter int QUIET_CYC    = 3,
  parameter int CNV_LOW_CYC  = 2,
  parameter int RD_CYC       = 3,
  parameter int ABORT_SU_CYC = 2,
  parameter int RST_CYC      = 10,
  parameter int WAKE_CYC     = 6,
  parameter int DROP_CNT     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              byteMode,
  input  logic              cvtResetReq,
  input  logic              abortReq,
  input  logic              busy,
  input  logic [DATA_W-1:0] dataIn,
  output logic              cnvStN,
  output logic              csN,
  output logic              rdN,
  output logic              byteSel,
  output logic              pwdRstN,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  input  logic              resReady
);

  pinSet_t   pins;
  dpStrobe_t strobe;
  logic      slotFree;

  sar_seq_ctrl #(
    .ACQ_CYC(ACQ_CYC), .QUIET_CYC(QUIET_CYC), .CNV_LOW_CYC(CNV_LOW_CYC),
    .RD_CYC(RD_CYC), .ABORT_SU_CYC(ABORT_SU_CYC), .RST_CYC(RST_CYC), .WAKE_CYC(WAKE_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .byteModeIn(byteMode),
    .cvtResetReq(cvtResetReq), .abortReq(abortReq), .busy(busy),
    .slotFree(slotFree), .pins(pins), .strobe(strobe)
  );

  sar_seq_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DROP_CNT(DROP_CNT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .resReady(resReady), .resData(resData), .resValid(resValid), .slotFree(slotFree)
  );

  assign cnvStN  = pins.cnvStN;
  assign csN     = pins.csN;
  assign rdN     = pins.rdN;
  assign byteSel = pins.byteSel;
  assign pwdRstN = pins.pwdRstN;

endmodule

// File: tb/sim_sar_host_seq.sv
module sim_sar_host_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ACQ = 8, QUIET = 3, CLOW = 2, RDC = 3, ASU = 2, RSTC = 10, WAKE = 6, DROP = 4;
  localparam int BUSY_DLY = 2, CONV_LEN = 28;

  logic clk = 0, rstN = 0, enable = 0, byteMode = 0, cvtResetReq = 0, abortReq = 0;
  logic busy = 0, resReady = 0;
  logic [13:0] dataIn = '0;
  logic cnvStN, csN, rdN, byteSel, pwdRstN, resValid;
  logic [13:0] resData;

  int nChecks = 0, nErrors = 0;
  bit finished = 0;
  string curTag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_host_seq #(
    .ACQ_CYC(ACQ), .QUIET_CYC(QUIET), .CNV_LOW_CYC(CLOW), .RD_CYC(RDC),
    .ABORT_SU_CYC(ASU), .RST_CYC(RSTC), .WAKE_CYC(WAKE), .DROP_CNT(DROP)
  ) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .byteMode(byteMode),
    .cvtResetReq(cvtResetReq), .abortReq(abortReq), .busy(busy), .dataIn(dataIn),
    .cnvStN(cnvStN), .csN(csN), .rdN(rdN), .byteSel(byteSel), .pwdRstN(pwdRstN),
    .resData(resData), .resValid(resValid), .resReady(resReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [13:0] sampleVal(input int n);
    case (n % 9)
      0: return 14'h0000;
      1: return 14'h3FFF;
      default: return 14'((n * 1237 + 91) & 16'h3FFF);
    endcase
  endfunction

  // Behavioural converter model and scoreboard, evaluated away from the active edge
  logic [13:0] expQ [256];
  int expWr = 0, expRd = 0;
  int mCyc = 0, mQuiet = 0, mCsFallCyc = 0, mCnvFallCyc = 0, mCnvRiseCyc = 0;
  int mCc = 0, mSeq = 0, mInvalid = DROP, mInvalidSeen = 0, mStarts = 0, mAborts = 0;
  int mResets = 0, mRstLen = 0;
  bit mConv = 0, mWake = 1;
  logic mPrevCs = 1, mPrevRd = 1, mPrevCnv = 1, mPrevPwd = 1;
  logic [13:0] mWord = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      mConv = 0; busy = 0; mWake = 1; mInvalid = DROP; mQuiet = 0;
      mPrevCs = 1; mPrevRd = 1; mPrevCnv = 1; mPrevPwd = 1;
      check(cnvStN && csN && rdN && pwdRstN && !byteSel && !resValid, "R1",
            {cnvStN, csN, rdN, pwdRstN, byteSel, resValid}, 6'b111100);
    end else begin
      mCyc++;
      if (csN != mPrevCs || rdN != mPrevRd) mQuiet = 0; else mQuiet++;
      if (mPrevCs && !csN) mCsFallCyc = mCyc;
      if (mPrevRd && !rdN) check(!mConv && !busy, "R3", mConv, 0);
      // conversion progress
      if (mConv) begin
        mCc++;
        if (mCc == BUSY_DLY) busy = 1;
        if (mCc == CONV_LEN) begin
          busy = 0; mConv = 0;
          if (mInvalid > 0) begin
            mInvalid--; mInvalidSeen++; mWord = 14'h2AAA;
          end else begin
            mWord = sampleVal(mSeq); mSeq++;
            expQ[expWr % 256] = mWord; expWr++;
          end
        end
      end
      // abort: chip-select falls while convert-start high and busy high
      if (mPrevCs && !csN && cnvStN && busy && mConv) begin
        check(mCyc - mCnvRiseCyc >= ASU, "R7", mCyc - mCnvRiseCyc, ASU);
        mConv = 0; busy = 0; mAborts++;
      end
      // conversion start
      if (mPrevCnv && !cnvStN) begin
        mCnvFallCyc = mCyc;
        if (!csN && pwdRstN && !mConv) begin
          mConv = 1; mCc = 0; mStarts++;
          if (mWake) check(mCyc - mCsFallCyc >= ACQ + WAKE, "R10", mCyc - mCsFallCyc, ACQ + WAKE);
          else       check(mCyc - mCsFallCyc >= ACQ, "R2", mCyc - mCsFallCyc, ACQ);
          check(mQuiet >= QUIET, "R2", mQuiet, QUIET);
          mWake = 0;
        end
      end
      if (!mPrevCnv && cnvStN) begin
        mCnvRiseCyc = mCyc;
        check(mCyc - mCnvFallCyc == CLOW, "R3", mCyc - mCnvFallCyc, CLOW);
      end
      // reset line
      if (!pwdRstN) begin
        mRstLen++; mConv = 0; busy = 0;
      end
      if (!mPrevPwd && pwdRstN) begin
        check(mRstLen == RSTC, "R8", mRstLen, RSTC);
        check(mRstLen * CLK_PERIOD >= 45 && mRstLen * CLK_PERIOD <= 6140, "R8", mRstLen * CLK_PERIOD, 45);
        mRstLen = 0; mInvalid = DROP; mWake = 1; mResets++;
      end
      // data bus
      if (!csN && !rdN) begin
        if (!byteMode) dataIn = mWord;
        else if (!byteSel) dataIn = {mWord[13:6], 6'b0};
        else dataIn = {mWord[5:0], 8'b0};
      end else begin
        dataIn = '0;
      end
      // scoreboard: handshake that completes at the next edge
      if (resValid && resReady) begin
        if (expRd < expWr) begin
          check(resData == expQ[expRd % 256], curTag, resData, expQ[expRd % 256]);
        end else begin
          check(0, "R9", resData, -1);
        end
        expRd++;
      end
      mPrevCs = csN; mPrevRd = rdN; mPrevCnv = cnvStN; mPrevPwd = pwdRstN;
    end
  end

  task automatic waitResults(input int n, input string tag);
    int target = expRd + n;
    for (int i = 0; i < 20000 && expRd < target; i++) @(negedge clk);
    check(expRd >= target, tag, expRd, target);
  endtask

  task automatic goIdle();
    @(posedge clk); #1 enable = 0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (4) @(negedge clk);
    @(posedge clk); #1 rstN = 1;
  endtask

  task automatic t_word_drop();   // R4, R9, R10
    curTag = "R4";
    @(posedge clk); #1 byteMode = 0; resReady = 1; enable = 1;
    waitResults(6, "R4");
    check(mInvalidSeen == DROP, "R9", mInvalidSeen, DROP);
    goIdle();
  endtask

  task automatic t_byte();        // R5
    curTag = "R5";
    @(posedge clk); #1 byteMode = 1; resReady = 1; enable = 1;
    waitResults(9, "R5");
    goIdle();
    @(posedge clk); #1 byteMode = 0;
  endtask

  task automatic t_stall();       // R6
    logic [13:0] held;
    int startsAt;
    curTag = "R6";
    @(posedge clk); #1 resReady = 0; enable = 1;
    for (int i = 0; i < 2000 && !resValid; i++) @(negedge clk);
    check(resValid, "R6", resValid, 1);
    held = resData; startsAt = mStarts;
    repeat (200) @(negedge clk);
    check(resValid, "R6", resValid, 1);
    check(resData == held, "R6", resData, held);
    check(mStarts == startsAt, "R6", mStarts, startsAt);
    @(posedge clk); #1 resReady = 1;
    waitResults(3, "R6");
    goIdle();
  endtask

  task automatic t_abort();       // R7
    int abortsAt = mAborts;
    int seqAt;
    curTag = "R7";
    @(posedge clk); #1 resReady = 1; enable = 1;
    for (int i = 0; i < 2000 && !busy; i++) @(negedge clk);
    @(posedge clk); #1 abortReq = 1;
    @(posedge clk); #1 abortReq = 0;
    seqAt = mSeq;
    repeat (40) @(negedge clk);
    check(mAborts == abortsAt + 1, "R7", mAborts, abortsAt + 1);
    check(mSeq == seqAt, "R7", mSeq, seqAt);
    waitResults(3, "R7");
    goIdle();
  endtask

  task automatic t_reset_pulse(); // R8, R9, R10
    int resetsAt = mResets;
    int invAt = mInvalidSeen;
    curTag = "R9";
    @(posedge clk); #1 cvtResetReq = 1;
    @(posedge clk); #1 cvtResetReq = 0;
    repeat (30) @(negedge clk);
    check(mResets == resetsAt + 1, "R8", mResets, resetsAt + 1);
    @(posedge clk); #1 resReady = 1; enable = 1;
    waitResults(3, "R9");
    check(mInvalidSeen - invAt == DROP, "R9", mInvalidSeen - invAt, DROP);
    goIdle();
  endtask

  task automatic t_enable_off();  // R11
    int startsAt = mStarts;
    repeat (150) @(negedge clk);
    check(mStarts == startsAt, "R11", mStarts, startsAt);
    check(csN && cnvStN, "R11", {csN, cnvStN}, 2'b11);
  endtask

  initial begin
    t_reset();
    t_word_drop();
    t_byte();
    t_stall();
    t_abort();
    t_reset_pulse();
    t_enable_off();
    check(expRd == expWr, "R6", expRd, expWr);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule